// File: doc/BRIEF.md
# Counter Snapshot Capture Unit with Software Trigger

This block takes a snapshot of a free-running 12-bit counter when an event arrives. A hardware event is an edge, of a polarity chosen by configuration, on either an external input pin or a comparator output. The hardware source first passes through a two-stage synchronizer and then an edge detector. Software can also force a snapshot by writing the trigger bit in the high byte of the capture register. That same bit, when read, tells whether the most recent snapshot came from software (1) or from hardware (0).

The snapshot is read over an 8-bit register bus. Reading the low byte copies the matching high byte into a temporary latch in the same cycle. A later read of the high byte returns that latch, so the two bytes always come from the same snapshot even if a new capture lands between the two reads. A one-cycle done pulse marks every update of the capture register.

Top module: `icap_unit`

## Requirements
- R1: After reset the low byte and high byte both read 0x00, and `cap_done_o` is low.
- R2: With capture enabled, edge select rising and source pin (`src_sel_i`=0), a rising edge on `pin_i` loads `cnt_i` into the capture register. The value loaded is the counter value at the third rising clock edge after the pin changes. The source flag then reads 0.
- R3: With `edge_rise_i`=0, only a falling edge of the selected source causes a capture. A rising edge is ignored.
- R4: With `src_sel_i`=1 the comparator input `cmp_i` is the hardware source, and edges on `pin_i` are ignored.
- R5: With `cap_en_i`=0, hardware edges cause no capture and the capture register keeps its value.
- R6: A bus write to address 1 with data bit 7 set captures `cnt_i` at that clock edge, whatever the value of `cap_en_i`, and sets the source flag to 1. A write to address 0, or a write to address 1 with bit 7 clear, changes nothing.
- R7: Address 0 reads capture bits [7:0]. Address 1 reads {flag, 3'b000, capture bits [11:8]}.
- R8: A read of address 0 (`bus_rd_i`=1) copies the high-byte image of the current capture into the temporary latch. A read of address 1 returns the latch and not the live register.
- R9: When a hardware event and a software trigger fall on the same clock edge, exactly one capture happens and the flag reads 1.
- R10: `cap_done_o` is high for exactly one cycle after each clock edge that updates the capture register, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 12 | Free-running counter value to snapshot |
| pin_i | input | 1 | External event pin (asynchronous) |
| cmp_i | input | 1 | Comparator output, alternative event source |
| cap_en_i | input | 1 | Enables hardware-triggered captures |
| src_sel_i | input | 1 | Hardware source: 0 = pin, 1 = comparator |
| edge_rise_i | input | 1 | Edge polarity: 1 = rising, 0 = falling |
| bus_addr_i | input | 1 | Byte select: 0 = low, 1 = high |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data (bit 7 = software trigger) |
| bus_rdata_o | output | 8 | Read data for the selected byte |
| cap_done_o | output | 1 | One-cycle pulse after each capture |

## Verification
The hardest case to reach is a hardware edge and a software write landing on the same clock edge. The pin edge only becomes an internal event after the synchronizer latency. The bench therefore changes the pin and counts two clock edges before it drives the trigger write, so both sources hit the third edge together. A second hard case is a capture that arrives between a low-byte read and a high-byte read. The bench reads the low byte, forces a new capture with a different high nibble and flag, and then expects the high-byte read to return the old snapshot.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int unsigned CAP_W = 12;
  localparam int unsigned BUS_W = 8;
  localparam int unsigned HI_W  = CAP_W - BUS_W;

  typedef enum logic { SRC_PIN = 1'b0, SRC_CMP = 1'b1 } src_e;

  // edge qualifier: rising when rise=1, falling otherwise
  function automatic logic edge_hit(input logic cur, input logic prev, input logic rise);
    return rise ? (cur & ~prev) : (~cur & prev);
  endfunction

  // high-byte image: flag on top, zero padding, upper capture bits at the bottom
  function automatic logic [BUS_W-1:0] pack_hi(input logic flag, input logic [HI_W-1:0] hi);
    logic [BUS_W-1:0] r;
    r = '0;
    r[BUS_W-1] = flag;
    r[HI_W-1:0] = hi;
    return r;
  endfunction
endpackage

// File: rtl/icap_edge.sv
module icap_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic cmp_i,
  input  logic src_sel_i,
  input  logic rise_i,
  output logic edge_o
);
  import icap_pkg::*;

  logic          src;
  logic [STAGES:0] sh_q;

  assign src = (src_e'(src_sel_i) == SRC_CMP) ? cmp_i : pin_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], src};
  end

  // sh_q[STAGES-1] is the last synchronized sample, sh_q[STAGES] its predecessor
  assign edge_o = edge_hit(sh_q[STAGES-1], sh_q[STAGES], rise_i);
endmodule

// File: rtl/icap_store.sv
module icap_store
  import icap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_evt,
  input  logic             sw_trig,
  input  logic [CAP_W-1:0] cnt_i,
  output logic [CAP_W-1:0] cap_q,
  output logic             flag_q,
  output logic             done_o
);
  logic take;
  assign take = hw_evt | sw_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= take;
      if (take) begin
        cap_q  <= cnt_i;
        flag_q <= sw_trig;   // software wins a tie
      end
    end
  end
endmodule

// File: rtl/icap_rdpath.sv
module icap_rdpath
  import icap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_i,
  input  logic             addr_i,
  input  logic [CAP_W-1:0] cap_q,
  input  logic             flag_q,
  output logic [BUS_W-1:0] temp_q,
  output logic [BUS_W-1:0] rdata_o
);
  logic lo_rd;
  assign lo_rd = rd_i & ~addr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     temp_q <= '0;
    else if (lo_rd) temp_q <= pack_hi(flag_q, cap_q[CAP_W-1:BUS_W]);
  end

  assign rdata_o = addr_i ? temp_q : cap_q[BUS_W-1:0];
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CAP_W-1:0] cnt_i,
  input  logic             pin_i,
  input  logic             cmp_i,
  input  logic             cap_en_i,
  input  logic             src_sel_i,
  input  logic             edge_rise_i,
  input  logic             bus_addr_i,
  input  logic             bus_rd_i,
  input  logic             bus_wr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic             cap_done_o
);
  logic             edge_s;
  logic             hw_evt;
  logic             sw_trig;
  logic [CAP_W-1:0] cap_q;
  logic             flag_q;
  logic [BUS_W-1:0] temp_q;
  logic             wdata_unused;

  assign wdata_unused = ^bus_wdata_i[BUS_W-2:0];

  icap_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cmp_i(cmp_i),
    .src_sel_i(src_sel_i), .rise_i(edge_rise_i), .edge_o(edge_s)
  );

  assign hw_evt  = cap_en_i & edge_s;
  assign sw_trig = bus_wr_i & bus_addr_i & bus_wdata_i[BUS_W-1];

  icap_store u_store (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .sw_trig(sw_trig),
    .cnt_i(cnt_i), .cap_q(cap_q), .flag_q(flag_q), .done_o(cap_done_o)
  );

  icap_rdpath u_rd (
    .clk(clk), .rst_n(rst_n), .rd_i(bus_rd_i), .addr_i(bus_addr_i),
    .cap_q(cap_q), .flag_q(flag_q), .temp_q(temp_q), .rdata_o(bus_rdata_o)
  );
endmodule

module icap_unit_chk
  import icap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [CAP_W-1:0] cnt_i,
  input logic             cap_en_i,
  input logic             bus_addr_i,
  input logic             bus_rd_i,
  input logic [BUS_W-1:0] bus_rdata_o,
  input logic             cap_done_o,
  input logic             hw_evt,
  input logic             sw_trig,
  input logic [CAP_W-1:0] cap_q,
  input logic             flag_q,
  input logic [BUS_W-1:0] temp_q
);
  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt || sw_trig) |=> cap_q == $past(cnt_i));
  // R2
  hw_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt && !sw_trig) |=> !flag_q);
  // R5
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en_i |-> !hw_evt);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_evt || sw_trig) |=> $stable(cap_q) && $stable(flag_q));
  // R6
  sw_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trig |=> flag_q);
  // R7
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_i |-> bus_rdata_o[BUS_W-2:HI_W] == '0);
  // R8
  latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && !bus_addr_i) |=>
      temp_q[HI_W-1:0] == $past(cap_q[CAP_W-1:BUS_W]) && temp_q[BUS_W-1] == $past(flag_q));
  // R8
  latch_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_i && !bus_addr_i) |=> $stable(temp_q));
  // R10
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_evt || sw_trig) |=> cap_done_o);
  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_evt || sw_trig) |=> !cap_done_o);
endmodule

bind icap_unit icap_unit_chk u_chk (.*);

// File: tb/icap_unit_test.sv
module icap_unit_test;
  localparam int CLK_P = 10;

  typedef struct { logic [11:0] v; logic f; } exp_t;

  logic        clk = 0, rst_n = 0;
  logic [11:0] cnt_i = '0;
  logic        pin_i = 0, cmp_i = 0, cap_en_i = 0, src_sel_i = 0, edge_rise_i = 1;
  logic        bus_addr_i = 0, bus_rd_i = 0, bus_wr_i = 0;
  logic [7:0]  bus_wdata_i = '0;
  logic [7:0]  bus_rdata_o;
  logic        cap_done_o;

  int   n_run = 0, n_fail = 0;
  bit   ended = 0;
  exp_t sb_q[$];
  exp_t last = '{v: 12'h000, f: 1'b0};

  icap_unit uut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every done pulse must match an expected capture
  always @(negedge clk) begin
    if (rst_n && cap_done_o) begin
      if (sb_q.size() == 0) check("R5/R10 unexpected capture", 16'd1, 16'd0);
      else begin
        last = sb_q.pop_front();
        n_run++;
      end
    end
  end

  task automatic settle(string req);
    repeat (5) @(negedge clk);
    #1;
    check({req, " pending captures"}, 16'(sb_q.size()), 16'd0);
    @(negedge clk);
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr_i = a; bus_rd_i = 1;
    #1 d = bus_rdata_o;
    @(negedge clk);
    bus_rd_i = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1;
    @(negedge clk);
    bus_wr_i = 0; bus_wdata_i = '0;
  endtask

  task automatic check_regs(string req);
    logic [7:0] lo, hi;
    rd(1'b0, lo);
    rd(1'b1, hi);
    check({req, " low byte"}, 16'(lo), 16'(last.v[7:0]));
    check({req, " high byte"}, 16'(hi), 16'({last.f, 3'b000, last.v[11:8]}));
  endtask

  task automatic sw_cap(logic [11:0] c);
    cnt_i = c;
    sb_q.push_back('{v: c, f: 1'b1});
    wr(1'b1, 8'h80);
  endtask

  task automatic set_pin(logic v, bit expect_cap);
    if (expect_cap) sb_q.push_back('{v: cnt_i, f: 1'b0});
    pin_i = v;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 done low", 16'(cap_done_o), 16'd0);
    check_regs("R1");

    // R2 rising edge on pin
    cap_en_i = 1; cnt_i = 12'h3A7;
    set_pin(1'b1, 1);
    settle("R2");
    check_regs("R2");
    set_pin(1'b0, 0);   // falling edge ignored under rising polarity
    settle("R3 falling ignored");

    // R3 falling polarity
    edge_rise_i = 0; cnt_i = 12'h5C1;
    set_pin(1'b1, 0);
    settle("R3 rising ignored");
    set_pin(1'b0, 1);
    settle("R3");
    check_regs("R3");
    edge_rise_i = 1;
    settle("R3 restore");

    // R4 comparator source
    src_sel_i = 1; cnt_i = 12'h0F0;
    set_pin(1'b1, 0);
    settle("R4 pin ignored");
    check_regs("R4 pin ignored");
    pin_i = 0;
    sb_q.push_back('{v: cnt_i, f: 1'b0});
    cmp_i = 1;
    settle("R4");
    check_regs("R4");
    cmp_i = 0; src_sel_i = 0;
    settle("R4 restore");

    // R5 disabled: edges ignored, value held
    cap_en_i = 0; cnt_i = 12'hEEE;
    set_pin(1'b1, 0);
    settle("R5");
    set_pin(1'b0, 0);
    settle("R5");
    check_regs("R5");

    // R6 software trigger while disabled
    sw_cap(12'hABC);
    settle("R6");
    check_regs("R6");
    cnt_i = 12'h111;
    wr(1'b0, 8'hFF);      // low-byte write ignored
    wr(1'b1, 8'h7F);      // trigger bit clear: ignored
    settle("R6 ignored writes");
    check_regs("R6 ignored writes");

    // R8 latch coherence across a new capture
    rd(1'b0, d);
    check("R7 low byte", 16'(d), 16'h0BC);
    cap_en_i = 1; cnt_i = 12'h5DE;
    set_pin(1'b1, 1);
    settle("R8 new capture");
    rd(1'b1, d);
    check("R8 stale high from latch", 16'(d), 16'h008A);
    check_regs("R8 fresh pair");
    pin_i = 0;
    settle("R8 restore");

    // R9 simultaneous hardware and software
    cnt_i = 12'h2D4;
    sb_q.push_back('{v: cnt_i, f: 1'b1});
    pin_i = 1;
    @(negedge clk);
    @(negedge clk);
    wr(1'b1, 8'h80);
    settle("R9");
    check_regs("R9");

    // R10 back-to-back software captures give two pulses
    sw_cap(12'h001);
    sw_cap(12'h002);
    settle("R10");
    check_regs("R10");
    check("R10 done low at rest", 16'(cap_done_o), 16'd0);

    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!ended) begin
      ended = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule